// File: doc/BRIEF.md
# Test Bandwidth Matching Adapter

This block lets a few fast, tester-driven test access wires carry many slower scan-rate wires into and out of an embedded core wrapper. Each fast input wire is collected over a group of fast clock cycles into a parallel word. That word is presented to the core side as a bank of slow stimulus wires, held steady for a whole slow period. In the other direction, each bank of slow response wires is captured once per slow period and sent back out on one fast wire, one bit per fast cycle.

Both directions run from the fast clock. A slow-rate strobe, derived from a modulo-ratio counter, marks the fast cycle on which the slow side advances. A test-enable input freezes the whole adapter: the phase counter, the shift registers and every output keep their values while it is low.

The ratio is a parameter, and so is the number of fast lanes. Their product is the virtual slow width. It must stay at or below a configured cap, which is the width past which the slowest core's test time no longer improves. Elaboration stops if the product exceeds the cap or if the ratio is below two.

Top module: `bwm_adapter`

## Requirements
- R1: A synchronous reset, sampled on a rising clock edge, clears every slow stimulus wire, every fast output wire and the strobe to 0 by the following cycle.
- R2: While test_en is high, slow_stb is high for exactly one fast cycle in every RATIO cycles. It first rises in the cycle that follows the (RATIO-1)th enabled edge after reset.
- R3: On lane j, the fast bit sampled first in a group lands on slow_stim[j*RATIO+0], and the bit sampled k-th lands on slow_stim[j*RATIO+k].
- R4: slow_stim changes only on an edge at which slow_stb is high, so each word stays stable for RATIO enabled cycles.
- R5: The first valid stimulus word appears after the RATIO-th enabled edge following reset. Before that, slow_stim reads all zeros.
- R6: On each strobe edge, every lane captures its RATIO response wires. Fast output j then presents slow_resp[j*RATIO+0] in the cycle after capture, followed by ascending indices, one per enabled cycle.
- R7: Values on slow_resp at edges without the strobe have no effect on fast_so.
- R8: While test_en is low, slow_stb stays low, the phase does not advance, fast_si is ignored, and slow_stim and fast_so hold their values. Raising test_en again resumes at the same phase.
- R9: Lanes are independent: the stimulus and response of one lane never depend on another lane's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at the tester data rate |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Enables the phase counter and shifting; low freezes everything |
| fast_si | input | LANES | One serial stimulus bit per fast lane |
| slow_resp | input | LANES*RATIO | Slow response wires, lane j in bits j*RATIO upward |
| fast_so | output | LANES | One serial response bit per fast lane |
| slow_stim | output | LANES*RATIO | Held slow stimulus wires, lane j in bits j*RATIO upward |
| slow_stb | output | 1 | One-cycle strobe marking a slow-period boundary |

## Verification
The bench builds the adapter with two lanes at ratio four, a virtual width of eight under a cap of sixteen. Two lanes let distinct per-lane patterns, including one lane all ones next to one lane all zeros, expose any cross-lane wiring or index swap. Ratio four gives several interior bit positions, so the hold interval, the first-word latency and the serial order can each be observed cycle by cycle. It also lets a pause land mid-period and show that the phase resumes correctly.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // Flat slow-wire index for bit position pos of fast lane lane.
  function automatic int unsigned slow_index(input int unsigned lane,
                                             input int unsigned pos,
                                             input int unsigned ratio);
    return lane * ratio + pos;
  endfunction

  // True on the last phase of a slow period.
  function automatic bit phase_is_last(input int unsigned phase,
                                       input int unsigned ratio);
    return phase == ratio - 1;
  endfunction

  // Virtual width permitted by the cap.
  function automatic bit width_fits(input int unsigned lanes,
                                    input int unsigned ratio,
                                    input int unsigned cap);
    return (lanes * ratio) <= cap;
  endfunction

endpackage

// File: rtl/bwm_strobe_gen.sv
module bwm_strobe_gen #(
  parameter int unsigned RATIO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic test_en,
  output logic stb
);
  import bwm_pkg::*;

  localparam int unsigned CW = (RATIO > 2) ? $clog2(RATIO) : 1;

  logic [CW-1:0] phase_q;
  logic          wrap;

  assign wrap = phase_is_last(32'(phase_q), RATIO);
  assign stb  = test_en & wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (test_en) begin
      phase_q <= wrap ? '0 : phase_q + 1'b1;
    end
  end

  // R2: the strobe never lasts more than one cycle
  assert_stb_single_R2: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);

  // R8: a frozen adapter keeps its phase
  assert_phase_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> $stable(phase_q));

endmodule

// File: rtl/bwm_sipo.sv
module bwm_sipo #(
  parameter int unsigned RATIO = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             stb,
  input  logic             si,
  output logic [RATIO-1:0] par_o
);
  logic [RATIO-1:0] sr_q;
  logic [RATIO-1:0] sr_next;
  logic [RATIO-1:0] hold_q;

  // oldest bit drifts toward index 0
  assign sr_next = {si, sr_q[RATIO-1:1]};
  assign par_o   = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      hold_q <= '0;
    end else begin
      if (en)  sr_q   <= sr_next;
      if (stb) hold_q <= sr_next;
    end
  end

  // R4: held word moves only on the strobe
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(hold_q));

  // R3: the bit sampled on the strobe edge is the newest, at the top index
  assert_newest_top_R3: assert property (@(posedge clk) disable iff (rst)
    stb |=> hold_q[RATIO-1] == $past(si));

endmodule

// File: rtl/bwm_piso.sv
module bwm_piso #(
  parameter int unsigned RATIO = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ld,
  input  logic [RATIO-1:0] par_i,
  output logic             so
);
  logic [RATIO-1:0] psr_q;

  assign so = psr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_q <= '0;
    end else if (ld) begin
      psr_q <= par_i;
    end else if (en) begin
      psr_q <= {1'b0, psr_q[RATIO-1:1]};
    end
  end

  // R6: lowest-index wire leads after a load
  assert_load_first_R6: assert property (@(posedge clk) disable iff (rst)
    ld |=> so == $past(par_i[0]));

  // R8: serial output frozen while disabled
  assert_so_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(so));

endmodule

// File: rtl/bwm_adapter.sv
module bwm_adapter #(
  parameter int unsigned LANES     = 2,
  parameter int unsigned RATIO     = 4,
  parameter int unsigned WIDTH_CAP = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     test_en,
  input  logic [LANES-1:0]         fast_si,
  input  logic [LANES*RATIO-1:0]   slow_resp,
  output logic [LANES-1:0]         fast_so,
  output logic [LANES*RATIO-1:0]   slow_stim,
  output logic                     slow_stb
);
  import bwm_pkg::*;

  localparam int unsigned VWIDTH = LANES * RATIO;

  if (!width_fits(LANES, RATIO, WIDTH_CAP)) begin : g_cap_check
    $error("virtual width exceeds WIDTH_CAP");
  end
  if (RATIO < 2) begin : g_ratio_check
    $error("RATIO must be at least 2");
  end

  logic stb;

  bwm_strobe_gen #(.RATIO(RATIO)) u_stb (
    .clk     (clk),
    .rst     (rst),
    .test_en (test_en),
    .stb     (stb)
  );

  assign slow_stb = stb;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned BASE = slow_index(g, 0, RATIO);

    bwm_sipo #(.RATIO(RATIO)) u_sipo (
      .clk   (clk),
      .rst   (rst),
      .en    (test_en),
      .stb   (stb),
      .si    (fast_si[g]),
      .par_o (slow_stim[BASE +: RATIO])
    );

    bwm_piso #(.RATIO(RATIO)) u_piso (
      .clk   (clk),
      .rst   (rst),
      .en    (test_en),
      .ld    (stb),
      .par_i (slow_resp[BASE +: RATIO]),
      .so    (fast_so[g])
    );
  end

  // reset observer for the check below
  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= rst;

  always @(posedge clk) begin
    if (rst_seen_q) begin
      assert_reset_clear_R1: assert (slow_stim == '0 && fast_so == '0 && !stb)
        else $error("outputs not cleared after reset");
    end
  end

  // R2: a disabled adapter never strobes
  assert_no_stb_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    !test_en |-> !slow_stb);

  // R8: stimulus bank frozen while disabled
  assert_stim_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> $stable(slow_stim));

  logic unused_width;
  assign unused_width = (VWIDTH == 0);

endmodule

// File: tb/bwm_adapter_tb_top.sv
module bwm_adapter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 2;
  localparam int RATIO = 4;
  localparam int VW = LANES * RATIO;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic test_en = 1'b0;
  logic [LANES-1:0] fast_si = '0;
  logic [VW-1:0]    slow_resp = '0;
  logic [LANES-1:0] fast_so;
  logic [VW-1:0]    slow_stim;
  logic             slow_stb;

  bwm_adapter #(.LANES(LANES), .RATIO(RATIO), .WIDTH_CAP(16)) dut_i (
    .clk(clk), .rst(rst), .test_en(test_en), .fast_si(fast_si),
    .slow_resp(slow_resp), .fast_so(fast_so), .slow_stim(slow_stim),
    .slow_stb(slow_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int e = 0;
  bit finished = 0;
  logic [15:0] pat [LANES];
  string stim_tag = "";

  function automatic logic [VW-1:0] resp_word(input int w);
    logic [31:0] v;
    v = 32'hA5C3 ^ (w * 32'h9E37);
    return v[VW-1:0];
  endfunction

  function automatic logic [VW-1:0] exp_stim(input int ev);
    logic [VW-1:0] r;
    int w;
    r = '0;
    if (ev >= RATIO) begin
      w = ev / RATIO - 1;
      for (int j = 0; j < LANES; j++)
        for (int p = 0; p < RATIO; p++)
          r[j*RATIO+p] = pat[j][(w*RATIO+p) % 16];
    end
    return r;
  endfunction

  function automatic logic [LANES-1:0] exp_so(input int ev);
    logic [LANES-1:0] r;
    logic [VW-1:0] rw;
    r = '0;
    if (ev >= RATIO) begin
      rw = resp_word(ev / RATIO - 1);
      for (int j = 0; j < LANES; j++) r[j] = rw[j*RATIO + ev % RATIO];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (e=%0d)", tag, act, expv, e);
    end
  endtask

  // one fast cycle: drive at the falling edge, then compare
  task automatic step(input logic en_v);
    string t_stim, t_so, t_stb;
    @(negedge clk);
    test_en = en_v;
    for (int j = 0; j < LANES; j++)
      fast_si[j] = en_v ? pat[j][e % 16] : ~pat[j][e % 16];
    slow_resp = (e % RATIO == RATIO - 1) ? resp_word(e / RATIO) : ~resp_word(e / RATIO);
    #1;
    if (!en_v) begin
      t_stim = "R8"; t_so = "R8"; t_stb = "R8";
    end else begin
      t_so = "R6/R7"; t_stb = "R2";
      if (stim_tag != "")           t_stim = stim_tag;
      else if (e < RATIO)           t_stim = "R5";
      else if (e % RATIO == 0)      t_stim = "R3";
      else                          t_stim = "R4";
    end
    check(t_stb, 32'(slow_stb), 32'(en_v && (e % RATIO == RATIO - 1)));
    check(t_stim, 32'(slow_stim), 32'(exp_stim(e)));
    check(t_so, 32'(fast_so), 32'(exp_so(e)));
    if (en_v) e++;
  endtask

  // reset and check the cleared state
  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    test_en = 1'b0;
    @(negedge clk);
    check("R1 stim", 32'(slow_stim), 32'h0);
    check("R1 so", 32'(fast_so), 32'h0);
    check("R1 stb", 32'(slow_stb), 32'h0);
    rst = 1'b0;
    e = 0;
  endtask

  task automatic t_stream;
    stim_tag = "";
    pat[0] = 16'hB4C9;
    pat[1] = 16'h3A5E;
    do_reset();
    for (int i = 0; i < 16; i++) step(1'b1);
  endtask

  task automatic t_reset_mid;
    // outputs are nonzero here; R1 must clear them
    check("R1 precondition", 32'(slow_stim != '0), 32'h1);
    do_reset();
  endtask

  task automatic t_pause;
    stim_tag = "";
    pat[0] = 16'h6D21;
    pat[1] = 16'hC7F0;
    do_reset();
    for (int i = 0; i < 6; i++)  step(1'b1);
    for (int i = 0; i < 5; i++)  step(1'b0);
    for (int i = 0; i < 10; i++) step(1'b1);
  endtask

  task automatic t_lanes;
    stim_tag = "R9";
    pat[0] = 16'hFFFF;
    pat[1] = 16'h0000;
    do_reset();
    for (int i = 0; i < 12; i++) step(1'b1);
    stim_tag = "";
  endtask

  initial begin
    t_stream();
    t_reset_mid();
    t_pause();
    t_lanes();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule